// File: doc/BRIEF.md
# Packed Lane Equality Compare Unit

This execution unit compares two packed operands lane by lane for equality. Each operand is 64 or 128 bits wide. An opcode byte selects the lane size: 8, 16 or 32 bits. For each lane pair, the unit writes a result lane of all ones when the two lanes are equal and all zeros when they differ. An operand-size prefix flag that arrives with the opcode picks the operand width.

Before any result is produced, a fault stage looks at three control bits and at the alignment of a memory-sourced operand. It reports the single highest-priority fault, and a faulting operation returns a zero result.

The unit is fully pipelined. One operation can be issued every cycle, and each result appears two cycles after the operation is accepted. The unit has no flag outputs.

Top module: `simd_eqcmp_unit`

## Requirements
- R1: Opcode 0x74 selects 8-bit lanes, 0x75 selects 16-bit lanes and 0x76 selects 32-bit lanes.
- R2: With `opsize_pfx`=1 the operation covers all 128 bits (16, 8 or 4 lanes). With `opsize_pfx`=0 it covers bits 63:0 (8, 4 or 2 lanes), and `out_result[127:64]` is zero.
- R3: Each result lane is all ones when the destination and source lanes are equal and all zeros otherwise, so every result byte is 0x00 or 0xFF.
- R4: `out_valid` is high exactly two clock cycles after a cycle with `in_valid` high. When `out_valid` is low, `out_result` and `out_fault` are zero.
- R5: `out_fault` encoding: 0 = none, 1 = invalid opcode, 2 = unit not available, 3 = alignment protection. On a fault, `out_valid` is still raised and `out_result` is zero.
- R6: Fault 1 is raised when `cr_emul` is 1, when a 128-bit operation has `cr_fxsr_en`=0, or when the opcode is not 0x74, 0x75 or 0x76.
- R7: Fault 2 is raised when `cr_task_sw` is 1.
- R8: Fault 3 is raised when a 128-bit operation has `mem_src`=1 and `mem_addr[3:0]` nonzero. Neither 64-bit operations nor register sources are checked for alignment.
- R9: When several faults apply, only one is reported. Fault 1 wins over fault 2, and fault 2 wins over fault 3.
- R10: While `rst` is high and on the first cycle after it, all outputs are zero, and operations already in flight are discarded.
- R11: Operations issued on consecutive cycles each produce their own result, in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation accepted this cycle |
| opcode | input | 8 | Opcode byte selecting lane size |
| opsize_pfx | input | 1 | Operand-size prefix present (128-bit form) |
| mem_src | input | 1 | Source operand comes from memory |
| mem_addr | input | ADDR_W | Address of the memory source |
| cr_emul | input | 1 | Emulation control bit |
| cr_fxsr_en | input | 1 | Wide-state enable control bit |
| cr_task_sw | input | 1 | Task-switched control bit |
| dst_op | input | DATA_W | Destination operand |
| src_op | input | DATA_W | Source operand |
| out_valid | output | 1 | Result or fault valid |
| out_result | output | DATA_W | Lane mask result |
| out_fault | output | 2 | Fault code |

## Verification
The assertions check the following on every cycle:
- the two-cycle valid timing and the zero outputs while idle;
- that every result byte is a pure mask;
- that a faulting result is zero and the upper half of a 64-bit result is zero;
- that fault 1 wins whenever the emulation bit is set, and that fault 3 appears for misaligned wide memory operands when no other fault applies.

Only the bench's scenarios can show that:
- lane boundaries follow the decoded lane size;
- each priority combination yields the expected code;
- back-to-back operations keep their order;
- a reset discards an operation already in flight.

// File: rtl/simd_eqcmp_pkg.sv
`timescale 1ns/1ps
package simd_eqcmp_pkg;

  typedef enum logic [1:0] {
    LANE_B = 2'd0,
    LANE_W = 2'd1,
    LANE_D = 2'd2
  } lane_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_BADOP  = 2'd1,
    FLT_NOUNIT = 2'd2,
    FLT_ALIGN  = 2'd3
  } fault_e;

  localparam logic [7:0] OPC_EQ_B = 8'h74;
  localparam logic [7:0] OPC_EQ_W = 8'h75;
  localparam logic [7:0] OPC_EQ_D = 8'h76;

  typedef struct packed {
    logic  ok;
    lane_e lane;
    logic  wide;
  } dec_t;

endpackage

// File: rtl/eqcmp_decode.sv
`timescale 1ns/1ps
module eqcmp_decode
  import simd_eqcmp_pkg::*;
(
  input  logic [7:0] opcode,
  input  logic       opsize_pfx,
  output dec_t       dec
);

  always_comb begin
    dec.ok   = 1'b1;
    dec.wide = opsize_pfx;
    dec.lane = LANE_B;
    case (opcode)
      OPC_EQ_B: dec.lane = LANE_B;
      OPC_EQ_W: dec.lane = LANE_W;
      OPC_EQ_D: dec.lane = LANE_D;
      default:  dec.ok   = 1'b0;
    endcase
  end

endmodule

// File: rtl/eqcmp_fault_chk.sv
`timescale 1ns/1ps
module eqcmp_fault_chk
  import simd_eqcmp_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int ALIGN_BYTES = 16
) (
  input  dec_t              dec,
  input  logic              mem_src,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              cr_emul,
  input  logic              cr_fxsr_en,
  input  logic              cr_task_sw,
  output fault_e            fault
);

  localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'(ALIGN_BYTES - 1);

  logic badop;
  logic misaligned;

  assign badop      = !dec.ok || cr_emul || (dec.wide && !cr_fxsr_en);
  assign misaligned = dec.wide && mem_src && (|(mem_addr & ALIGN_MASK));

  // priority: bad opcode, then unit unavailable, then alignment
  always_comb begin
    fault = FLT_NONE;
    if (badop)           fault = FLT_BADOP;
    else if (cr_task_sw) fault = FLT_NOUNIT;
    else if (misaligned) fault = FLT_ALIGN;
  end

endmodule

// File: rtl/eqcmp_lane_array.sv
`timescale 1ns/1ps
module eqcmp_lane_array
  import simd_eqcmp_pkg::*;
#(
  parameter int DATA_W   = 128,
  parameter int NARROW_W = 64
) (
  input  logic [DATA_W-1:0] dst,
  input  logic [DATA_W-1:0] src,
  input  lane_e             lane,
  input  logic              wide,
  output logic [DATA_W-1:0] mask
);

  localparam int NB   = DATA_W / 8;
  localparam int NB_N = NARROW_W / 8;

  logic [NB-1:0] eq_b;
  logic [NB-1:0] eq_w;
  logic [NB-1:0] eq_d;
  logic [NB-1:0] sel;
  logic [NB-1:0] keep;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    assign eq_b[i] = (dst[8*i +: 8] == src[8*i +: 8]);
    assign keep[i] = wide || (i < NB_N);
  end

  // each byte takes the equality of the lane group it belongs to
  for (genvar i = 0; i < NB; i++) begin : g_group
    assign eq_w[i] = &eq_b[(i/2)*2 +: 2];
    assign eq_d[i] = &eq_b[(i/4)*4 +: 4];
  end

  always_comb begin
    case (lane)
      LANE_W:  sel = eq_w;
      LANE_D:  sel = eq_d;
      default: sel = eq_b;
    endcase
  end

  for (genvar i = 0; i < NB; i++) begin : g_mask
    assign mask[8*i +: 8] = {8{sel[i] & keep[i]}};
  end

endmodule

// File: rtl/simd_eqcmp_unit.sv
`timescale 1ns/1ps
module simd_eqcmp_unit
  import simd_eqcmp_pkg::*;
#(
  parameter int DATA_W      = 128,
  parameter int NARROW_W    = 64,
  parameter int ADDR_W      = 32,
  parameter int ALIGN_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        opcode,
  input  logic              opsize_pfx,
  input  logic              mem_src,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              cr_emul,
  input  logic              cr_fxsr_en,
  input  logic              cr_task_sw,
  input  logic [DATA_W-1:0] dst_op,
  input  logic [DATA_W-1:0] src_op,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result,
  output logic [1:0]        out_fault
);

  dec_t   dec0;
  fault_e flt0;

  eqcmp_decode u_dec (
    .opcode     (opcode),
    .opsize_pfx (opsize_pfx),
    .dec        (dec0)
  );

  eqcmp_fault_chk #(
    .ADDR_W      (ADDR_W),
    .ALIGN_BYTES (ALIGN_BYTES)
  ) u_flt (
    .dec        (dec0),
    .mem_src    (mem_src),
    .mem_addr   (mem_addr),
    .cr_emul    (cr_emul),
    .cr_fxsr_en (cr_fxsr_en),
    .cr_task_sw (cr_task_sw),
    .fault      (flt0)
  );

  // stage 1: operands, decoded lane control and fault
  logic              s1_v;
  lane_e             s1_lane;
  logic              s1_wide;
  fault_e            s1_flt;
  logic [DATA_W-1:0] s1_dst;
  logic [DATA_W-1:0] s1_src;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v    <= 1'b0;
      s1_lane <= LANE_B;
      s1_wide <= 1'b0;
      s1_flt  <= FLT_NONE;
      s1_dst  <= '0;
      s1_src  <= '0;
    end else begin
      s1_v    <= in_valid;
      s1_lane <= dec0.lane;
      s1_wide <= dec0.wide;
      s1_flt  <= flt0;
      s1_dst  <= dst_op;
      s1_src  <= src_op;
    end
  end

  logic [DATA_W-1:0] mask1;

  eqcmp_lane_array #(
    .DATA_W   (DATA_W),
    .NARROW_W (NARROW_W)
  ) u_lanes (
    .dst  (s1_dst),
    .src  (s1_src),
    .lane (s1_lane),
    .wide (s1_wide),
    .mask (mask1)
  );

  // stage 2: registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_fault  <= 2'd0;
    end else begin
      out_valid  <= s1_v;
      out_fault  <= s1_v ? s1_flt : FLT_NONE;
      out_result <= (s1_v && s1_flt == FLT_NONE) ? mask1 : '0;
    end
  end

endmodule

// File: rtl/simd_eqcmp_sva.sv
`timescale 1ns/1ps
module simd_eqcmp_sva #(
  parameter int DATA_W = 128,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [7:0]        opcode,
  input logic              opsize_pfx,
  input logic              mem_src,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              cr_emul,
  input logic              cr_fxsr_en,
  input logic              cr_task_sw,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_result,
  input logic [1:0]        out_fault
);

  function automatic logic pure_masks(logic [DATA_W-1:0] v);
    for (int i = 0; i < DATA_W/8; i++)
      if (v[8*i +: 8] != 8'h00 && v[8*i +: 8] != 8'hFF) return 1'b0;
    return 1'b1;
  endfunction

  logic opc_known;
  assign opc_known = (opcode == 8'h74) || (opcode == 8'h75) || (opcode == 8'h76);

  a_r4_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);
  a_r4_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##2 !out_valid);
  a_r4_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_result == '0 && out_fault == 2'd0));
  a_r3_pure_mask: assert property (@(posedge clk) disable iff (rst)
    pure_masks(out_result));
  a_r5_fault_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_fault != 2'd0) |-> out_result == '0);
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !opsize_pfx) |-> ##2 out_result[DATA_W-1:64] == '0);
  a_r9_emul_wins: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cr_emul) |-> ##2 out_fault == 2'd1);
  a_r8_misalign: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opc_known && !cr_emul && cr_fxsr_en && !cr_task_sw &&
     opsize_pfx && mem_src && mem_addr[3:0] != 4'd0) |-> ##2 out_fault == 2'd3);

endmodule

bind simd_eqcmp_unit simd_eqcmp_sva #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_sva (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .opcode     (opcode),
  .opsize_pfx (opsize_pfx),
  .mem_src    (mem_src),
  .mem_addr   (mem_addr),
  .cr_emul    (cr_emul),
  .cr_fxsr_en (cr_fxsr_en),
  .cr_task_sw (cr_task_sw),
  .out_valid  (out_valid),
  .out_result (out_result),
  .out_fault  (out_fault)
);

// File: tb/simd_eqcmp_unit_test.sv
`timescale 1ns/1ps
module simd_eqcmp_unit_test;

  typedef struct packed {
    logic [7:0]   opc;
    logic         pfx;
    logic         emul;
    logic         fxsr;
    logic         ts;
    logic         mem;
    logic [3:0]   alo;
    logic [127:0] d;
    logic [127:0] s;
    logic [1:0]   f;
  } vec_t;

  localparam logic [127:0] VA = 128'h00112233_44556677_8899AABB_CCDDEEFF;
  localparam logic [127:0] VB = 128'h00112299_44556600_8899AABB_CCDD0EFF;
  localparam logic [127:0] VC = 128'h00112233_44556677_8899AABB_CCDDEE00;
  localparam int NV = 16;

  // expected fault codes written by hand from R5..R9
  localparam vec_t VT [NV] = '{
    '{8'h74, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, VA, VB, 2'd0}, // R1 R3 bytes wide
    '{8'h75, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, VA, VB, 2'd0}, // R1 words wide
    '{8'h76, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, VA, VB, 2'd0}, // R1 dwords wide
    '{8'h74, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, VA, VB, 2'd0}, // R2 narrow bytes
    '{8'h75, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, VA, VC, 2'd0}, // R2 narrow words
    '{8'h76, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, VA, VA, 2'd0}, // R2 narrow equal
    '{8'h76, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, VA, VA, 2'd0}, // R3 all equal
    '{8'h74, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0, VA, VA, 2'd1}, // R6 emul
    '{8'h75, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, VA, VA, 2'd1}, // R6 wide no fxsr
    '{8'h74, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, VA, VB, 2'd0}, // R6 narrow no fxsr ok
    '{8'h77, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, VA, VA, 2'd1}, // R6 unknown opcode
    '{8'h76, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'h0, VA, VA, 2'd2}, // R7 task switched
    '{8'h74, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'h4, VA, VA, 2'd3}, // R8 misaligned
    '{8'h74, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'h4, VA, VB, 2'd0}, // R8 narrow unchecked
    '{8'h75, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'h8, VA, VA, 2'd2}, // R9 ts over align
    '{8'h74, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'h1, VA, VA, 2'd1}  // R9 badop first
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [7:0]   opcode = 8'h0;
  logic         opsize_pfx = 1'b0;
  logic         mem_src = 1'b0;
  logic [31:0]  mem_addr = 32'h0;
  logic         cr_emul = 1'b0;
  logic         cr_fxsr_en = 1'b1;
  logic         cr_task_sw = 1'b0;
  logic [127:0] dst_op = '0;
  logic [127:0] src_op = '0;
  logic [1:0]   cur_f = 2'd0;
  logic         out_valid;
  logic [127:0] out_result;
  logic [1:0]   out_fault;

  int checks = 0;
  int fails  = 0;
  logic chk_en = 1'b0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  simd_eqcmp_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
    .opsize_pfx(opsize_pfx), .mem_src(mem_src), .mem_addr(mem_addr),
    .cr_emul(cr_emul), .cr_fxsr_en(cr_fxsr_en), .cr_task_sw(cr_task_sw),
    .dst_op(dst_op), .src_op(src_op), .out_valid(out_valid),
    .out_result(out_result), .out_fault(out_fault)
  );

  function automatic logic [127:0] model(logic [7:0] opc, logic pfx,
                                         logic [127:0] d, logic [127:0] s,
                                         logic [1:0] f);
    logic [127:0] r = '0;
    int lb = (opc == 8'h74) ? 1 : (opc == 8'h75) ? 2 : 4;
    int nb = pfx ? 16 : 8;
    if (f != 2'd0) return '0;
    for (int b = 0; b < nb; b += lb) begin
      logic eq = 1'b1;
      for (int k = 0; k < lb; k++)
        if (d[(b+k)*8 +: 8] != s[(b+k)*8 +: 8]) eq = 1'b0;
      for (int k = 0; k < lb; k++) r[(b+k)*8 +: 8] = {8{eq}};
    end
    return r;
  endfunction

  // expectation pipeline: two cycles of latency (R4, R11)
  logic         e1v = 1'b0, e2v = 1'b0;
  logic [127:0] e1r = '0, e2r = '0;
  logic [1:0]   e1f = 2'd0, e2f = 2'd0;

  always @(posedge clk) begin
    if (rst) begin
      e1v <= 1'b0; e2v <= 1'b0;
      e1r <= '0; e2r <= '0; e1f <= 2'd0; e2f <= 2'd0;
    end else begin
      e1v <= in_valid;
      e1f <= in_valid ? cur_f : 2'd0;
      e1r <= in_valid ? model(opcode, opsize_pfx, dst_op, src_op, cur_f) : '0;
      e2v <= e1v; e2r <= e1r; e2f <= e1f;
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      checks++;
      if (out_valid !== e2v) begin
        fails++;
        $display("FAIL R4 out_valid actual=%0b expected=%0b", out_valid, e2v);
      end
      checks++;
      if (out_fault !== e2f) begin
        fails++;
        $display("FAIL R9 out_fault actual=%0d expected=%0d", out_fault, e2f);
      end
      checks++;
      if (out_result !== e2r) begin
        fails++;
        $display("FAIL R3 out_result actual=%h expected=%h", out_result, e2r);
      end
    end
  end

  task automatic drive(input vec_t v, input logic [27:0] hi);
    in_valid   = 1'b1;
    opcode     = v.opc;
    opsize_pfx = v.pfx;
    cr_emul    = v.emul;
    cr_fxsr_en = v.fxsr;
    cr_task_sw = v.ts;
    mem_src    = v.mem;
    mem_addr   = {hi, v.alo};
    dst_op     = v.d;
    src_op     = v.s;
    cur_f      = v.f;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: outputs held at zero during reset
    checks++;
    if (out_valid !== 1'b0 || out_result !== '0 || out_fault !== 2'd0) begin
      fails++;
      $display("FAIL R10 reset state actual=%b/%h/%0d expected=0/0/0",
               out_valid, out_result, out_fault);
    end
    chk_en = 1'b1;
    rst = 1'b0;
    // table walked back to back (R11), all requirements R1..R9
    for (int i = 0; i < NV; i++) begin
      drive(VT[i], 28'h1234560 + 28'(i));
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    // R10: an operation in flight is discarded by reset
    drive(VT[0], 28'h0);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R10 flushed out_valid actual=%0b expected=0", out_valid);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_result !== '0) begin
      fails++;
      $display("FAIL R10 after reset actual=%0b/%h expected=0/0", out_valid, out_result);
    end
    // R8: aligned wide memory source has no fault
    drive('{8'h74, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'h0, VB, VB, 2'd0}, 28'hABCDEF0);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk_en = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule